// File: doc/BRIEF.md
# Seconds and 256 Hz Counters

This block keeps two free-running time counts for a small system. One is a 24-bit
count of elapsed seconds. The other is an 8-bit count that steps 256 times per second.
A divider turns the system clock into each count's tick. Each divider ratio is a
parameter derived from the clock frequency, so a simulation can use short periods.

Software uses a byte-wide register port with a 3-bit address. Each counter has a
control register with an enable bit and a self-clearing clear strobe. The count values
can only be read. The seconds count is read as three bytes, least significant first.
Each counter is run by a two-state machine. `CH_IDLE` means paused and `CH_RUN` means
counting. The transitions are:

- START: from `CH_IDLE` to `CH_RUN` on a control write with the enable bit set.
- STOP: from `CH_RUN` to `CH_IDLE` on a control write with the enable bit clear.
- HOLD: no control write, or a write that leaves the enable bit unchanged, keeps the state.

Register map (address: content):

| Address | Content |
|---|---|
| 0 | seconds control |
| 1 | seconds bits 7:0 |
| 2 | seconds bits 15:8 |
| 3 | seconds bits 23:16 |
| 4 | fast control |
| 5 | fast count |
| 6, 7 | read as zero |

Control bit 0 is enable. Control bit 1 is the clear strobe.

Top module: `rtc_tick_counters`

## Requirements
- R1: After reset every address reads 0x00 and both counters are paused.
- R2: A control write with bit 0 = 1 to a paused counter starts it. The first increment lands exactly DIV clock edges after the write edge (DIV = SEC_DIV or FAST_DIV), because the divider restarts.
- R3: A control write with bit 0 = 0 pauses the counter and holds its value. A later enable resumes counting, and the next increment lands a full DIV edges after that enable.
- R4: A control write with bit 1 = 1 zeroes that counter and restarts its divider. A control read returns bit 0 = current enable and all other bits 0, so bit 1 never reads back as set.
- R5: A control write of 0x03 zeroes the counter and leaves it running. The first increment follows DIV edges later.
- R6: The seconds count is read at address 1 (bits 7:0), address 2 (bits 15:8) and address 3 (bits 23:16).
- R7: Writes to addresses 1, 2, 3 and 5 have no effect on any count. Addresses 6 and 7 read 0x00.
- R8: Each counter wraps from all ones to zero.
- R9: The fast counter has its control at address 4 with the same bit layout and its count at address 5. It steps once per FAST_DIV edges, while the seconds counter steps once per SEC_DIV edges.
- R10: Writing enable = 1 to a counter that is already running does not restart its divider or shift its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_addr | input | 3 | register address |
| bus_we | input | 1 | write strobe, one cycle per write |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for `bus_addr`, combinational |

## Verification
A corrupted channel state shows at once in bit 0 of the control readback. A divider that holds a wrong phase shows as a count byte that changes on the wrong clock edge. That error becomes visible within one tick period of the enable or clear write that should have aligned it. A wrong count value, such as a missed clear, a bad wrap or a lost pause, shows on the very next read of the affected byte. For that reason, the bench compares the addressed byte on every cycle against a model and does not wait for sparse reads.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int SEC_W  = 24;
    localparam int FAST_W = 8;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

    localparam logic [ADDR_W-1:0] A_SEC_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEC_B0    = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEC_B1    = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEC_B2    = 3'd3;
    localparam logic [ADDR_W-1:0] A_FAST_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] A_FAST_CNT  = 3'd5;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_t;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && !restart && (phase_q == LAST);
endmodule

// File: rtl/rtc_count_chan.sv
module rtc_count_chan
    import rtc_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIV   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_en,
    input  logic             ctrl_clr,
    output logic [WIDTH-1:0] count,
    output logic             running
);
    ch_state_t state_q, state_d;
    logic      restart, stop_req, inc, tick;
    logic [WIDTH-1:0] count_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state: START, STOP, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (ctrl_we && ctrl_en)  state_d = CH_RUN;
            CH_RUN:  if (ctrl_we && !ctrl_en) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        running  = 1'b0;
        restart  = 1'b0;
        stop_req = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                restart = ctrl_we && (ctrl_clr || ctrl_en);
            end
            CH_RUN: begin
                running  = 1'b1;
                restart  = ctrl_we && ctrl_clr;
                stop_req = ctrl_we && !ctrl_en;
            end
            default: ;
        endcase
    end

    rtc_tick_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (restart),
        .tick    (tick)
    );

    assign inc = tick && !stop_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (ctrl_we && ctrl_clr) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file
    import rtc_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SEC_W-1:0]  sec_count,
    input  logic [FAST_W-1:0] fast_count,
    input  logic              sec_run,
    input  logic              fast_run,
    output logic              sec_ctrl_we,
    output logic              fast_ctrl_we,
    output logic              ctrl_en,
    output logic              ctrl_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int SEC_BYTES = SEC_W / DATA_W;

    logic [DATA_W-1:0] sec_byte [SEC_BYTES];

    for (genvar b = 0; b < SEC_BYTES; b++) begin : g_sec_byte
        assign sec_byte[b] = sec_count[b*DATA_W +: DATA_W];
    end

    // only control addresses accept writes; count bytes are read-only
    always_comb begin
        sec_ctrl_we  = bus_we && (bus_addr == A_SEC_CTRL);
        fast_ctrl_we = bus_we && (bus_addr == A_FAST_CTRL);
        ctrl_en      = bus_wdata[CTRL_EN_BIT];
        ctrl_clr     = bus_wdata[CTRL_CLR_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_SEC_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, sec_run};
            A_SEC_B0:    bus_rdata = sec_byte[0];
            A_SEC_B1:    bus_rdata = sec_byte[1];
            A_SEC_B2:    bus_rdata = sec_byte[2];
            A_FAST_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, fast_run};
            A_FAST_CNT:  bus_rdata = fast_count;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_tick_counters.sv
module rtc_tick_counters
    import rtc_pkg::*;
#(
    parameter int CLK_HZ   = 32768,
    parameter int SEC_DIV  = CLK_HZ,
    parameter int FAST_DIV = CLK_HZ / 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_we,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata
);
    logic [SEC_W-1:0]  sec_count;
    logic [FAST_W-1:0] fast_count;
    logic              sec_run, fast_run;
    logic              sec_ctrl_we, fast_ctrl_we, ctrl_en, ctrl_clr;

    rtc_reg_file u_regs (
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .sec_count    (sec_count),
        .fast_count   (fast_count),
        .sec_run      (sec_run),
        .fast_run     (fast_run),
        .sec_ctrl_we  (sec_ctrl_we),
        .fast_ctrl_we (fast_ctrl_we),
        .ctrl_en      (ctrl_en),
        .ctrl_clr     (ctrl_clr),
        .bus_rdata    (bus_rdata)
    );

    rtc_count_chan #(.WIDTH(SEC_W), .DIV(SEC_DIV)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (sec_ctrl_we),
        .ctrl_en  (ctrl_en),
        .ctrl_clr (ctrl_clr),
        .count    (sec_count),
        .running  (sec_run)
    );

    rtc_count_chan #(.WIDTH(FAST_W), .DIV(FAST_DIV)) u_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (fast_ctrl_we),
        .ctrl_en  (ctrl_en),
        .ctrl_clr (ctrl_clr),
        .count    (fast_count),
        .running  (fast_run)
    );
endmodule

// File: rtl/rtc_tick_counters_chk.sv
module rtc_tick_counters_chk
    import rtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_we,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [23:0] sec_count,
    input logic [7:0]  fast_count,
    input logic        sec_run,
    input logic        fast_run
);
    AST_SEC_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_run && !(bus_we && bus_addr == A_SEC_CTRL)) |=> $stable(sec_count)); // R3

    AST_FAST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_run && !(bus_we && bus_addr == A_FAST_CTRL)) |=> $stable(fast_count)); // R3

    AST_SEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SEC_CTRL && bus_wdata[1]) |=> (sec_count == 24'd0)); // R4

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SEC_CTRL) |-> (bus_rdata == {7'd0, sec_run})); // R4

    AST_CLEAR_AND_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FAST_CTRL && bus_wdata[1:0] == 2'b11)
        |=> (fast_count == 8'd0 && fast_run)); // R5

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_count != $past(fast_count))
        |-> (fast_count == $past(fast_count) + 8'd1 || fast_count == 8'd0)); // R8
endmodule

bind rtc_tick_counters rtc_tick_counters_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .sec_count  (sec_count),
    .fast_count (fast_count),
    .sec_run    (sec_run),
    .fast_run   (fast_run)
);

// File: tb/test_rtc_tick_counters.sv
`timescale 1ns/1ps
module test_rtc_tick_counters;
    localparam int SDIV = 2;
    localparam int FDIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit auto_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_tick_counters #(.CLK_HZ(512), .SEC_DIV(SDIV), .FAST_DIV(FDIV)) i_rtc_tick_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // reference model, written from the requirements
    int m_sec, m_sdiv, m_fast, m_fdiv;
    bit m_sen, m_fen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_sdiv = 0; m_sen = 0;
            m_fast = 0; m_fdiv = 0; m_fen = 0;
        end else begin
            automatic bit sw = bus_we && bus_addr == 3'd0;
            automatic bit fw = bus_we && bus_addr == 3'd4;
            if (sw && bus_wdata[1]) begin m_sec = 0; m_sdiv = 0; end
            else if (sw && (!bus_wdata[0] || !m_sen)) m_sdiv = 0;
            else if (m_sen) begin
                if (m_sdiv == SDIV - 1) begin m_sdiv = 0; m_sec = (m_sec + 1) & 32'hFFFFFF; end
                else m_sdiv++;
            end
            if (sw) m_sen = bus_wdata[0];
            if (fw && bus_wdata[1]) begin m_fast = 0; m_fdiv = 0; end
            else if (fw && (!bus_wdata[0] || !m_fen)) m_fdiv = 0;
            else if (m_fen) begin
                if (m_fdiv == FDIV - 1) begin m_fdiv = 0; m_fast = (m_fast + 1) & 32'hFF; end
                else m_fdiv++;
            end
            if (fw) m_fen = bus_wdata[0];
        end
    end

    function automatic logic [7:0] exp_read(logic [2:0] a);
        case (a)
            3'd0:    return {7'd0, m_sen};
            3'd1:    return m_sec[7:0];
            3'd2:    return m_sec[15:8];
            3'd3:    return m_sec[23:16];
            3'd4:    return {7'd0, m_fen};
            3'd5:    return m_fast[7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_for(logic [2:0] a);
        case (a)
            3'd0, 3'd4:       return "R4";
            3'd1, 3'd2, 3'd3: return "R6";
            3'd5:             return "R9";
            default:          return "R7";
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %02h expected %02h", tag, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && auto_on && !done) chk(tag_for(bus_addr), bus_rdata, exp_read(bus_addr));
    end

    // write captured at the next edge, then park the address for reads
    task automatic wr(logic [2:0] a, logic [7:0] d, logic [2:0] park);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = park;
    endtask

    task automatic rd(int k, string tag, logic [7:0] exp);
        repeat (k) @(posedge clk);
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state on every address
        for (int a = 0; a < 8; a++) begin
            @(posedge clk); #1 bus_addr = 3'(a);
            @(negedge clk); chk("R1", bus_rdata, 8'h00);
        end
        auto_on = 1'b1;

        // R2: first increment a full period after enable
        wr(3'd4, 8'h01, 3'd5);
        rd(FDIV - 1, "R2", 8'd0);
        rd(1, "R2", 8'd1);
        rd(FDIV, "R9", 8'd2);
        // R3: pause holds, resume waits a full period
        wr(3'd4, 8'h00, 3'd5);
        rd(20, "R3", 8'd2);
        wr(3'd4, 8'h01, 3'd5);
        rd(FDIV - 1, "R3", 8'd2);
        rd(1, "R3", 8'd3);
        // R10: rewrite of enable while running keeps phase
        wr(3'd4, 8'h01, 3'd5);
        rd(2, "R10", 8'd3);
        rd(1, "R10", 8'd4);
        // R5: clear and enable together
        wr(3'd4, 8'h03, 3'd5);
        rd(0, "R5", 8'd0);
        rd(FDIV - 1, "R5", 8'd0);
        rd(1, "R5", 8'd1);
        // R4: clear only; bit 1 never reads back
        wr(3'd4, 8'h02, 3'd4);
        rd(0, "R4", 8'h00);
        wr(3'd5, 8'hA5, 3'd5);
        rd(0, "R7", 8'h00);
        wr(3'd4, 8'h01, 3'd4);
        rd(0, "R4", 8'h01);
        // R8: wrap of the fast counter
        wr(3'd4, 8'h03, 3'd5);
        rd(255 * FDIV, "R8", 8'd255);
        rd(FDIV, "R8", 8'd0);
        // R6: seconds middle byte carries from the low byte
        wr(3'd0, 8'h03, 3'd2);
        rd(256 * SDIV - 1, "R6", 8'd0);
        rd(1, "R6", 8'd1);
        wr(3'd2, 8'hFF, 3'd2);
        rd(0, "R7", 8'd1);

        // constrained random traffic, checked every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            automatic logic [2:0] a = 3'($urandom_range(7));
            automatic logic [7:0] d = 8'($urandom);
            automatic bit w = ($urandom_range(1) == 1);
            if ((a == 3'd0 || a == 3'd4) && $urandom_range(7) != 0) d[1] = 1'b0;
            @(posedge clk); #1;
            bus_we = w; bus_addr = a; bus_wdata = d;
            @(posedge clk); #1;
            bus_we = 1'b0; bus_addr = 3'($urandom_range(7));
            repeat ($urandom_range(12)) @(posedge clk);
        end
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule